// File: doc/BRIEF.md
# Five-mode barrel shifter

This block reshapes the second operand of a data-processing path in a single combinational pass. It takes a 32-bit operand, a 3-bit mode code, a 5-bit amount and the current carry flag. It returns the shifted operand and a carry-out taken from the last bit that was pushed out. Logic outside the block decides whether the amount comes from an immediate field or from the low bits of a register.

The block supports five operations:
- two logical shifts, one in each direction;
- an arithmetic right shift that copies the sign bit into the vacated positions;
- a plain right rotation;
- a one-bit rotation through the carry flag.

A zero amount has a defined meaning in every mode. For a plain rotation, a zero amount selects the rotation through carry, so an amount of 0 in that mode never returns the operand unchanged.

Top module: `barrel_shift5`

## Requirements
- R1: With mode code 0 (left shift) and amount n in 1..31, the result is the operand moved n places toward bit 31, and the n lowest result bits are 0.
- R2: With mode code 1 (logical right shift) and amount n in 1..31, the result is the operand moved n places toward bit 0, and the n highest result bits are 0.
- R3: With mode code 2 (arithmetic right shift) and amount n in 1..31, the n highest result bits are copies of operand bit 31. For example, 0x92345678 shifted by 8 gives 0xFF923456.
- R4: With mode code 3 (rotate right) and amount n in 1..31, bits that leave bit 0 re-enter at bit 31. For example, 0x92345678 rotated by 8 gives 0x78923456.
- R5: With mode code 0, 1 or 2 and amount 0, the result equals the operand and carry-out equals carry-in.
- R6: For a nonzero amount n in modes 0 to 3, carry-out is the last bit shifted out. In mode 0 that is operand bit 32-n. In modes 1, 2 and 3 it is operand bit n-1.
- R7: Mode code 3 with amount 0 rotates one place through the carry. The result is {carry_in, operand[31:1]} and carry-out is operand[0].
- R8: Mode code 4 always performs the one-place rotation through carry described in R7, whatever the amount.
- R9: Mode codes 5, 6 and 7 return the operand unchanged, with carry-out equal to carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_value | input | 32 | Operand to be shifted or rotated |
| op_mode | input | 3 | Operation code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| op_amount | input | 5 | Shift or rotate distance |
| carry_in | input | 1 | Current carry flag |
| shift_result | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Carry produced by the operation |

## Verification
The operand 0x92345678 is shifted by 8 in every direction. Because its sign bit is set, an arithmetic shift gives a different result from a logical shift, and a rotation gives a different result from a plain shift. A positive operand run through the same arithmetic shift confirms that the fill follows bit 31 and is not forced to ones.

Amounts 0, 1 and 31 are tried with single set bits placed at the edges of the word. These cases expose off-by-one errors in the carry index and confirm the special meaning of amount 0, both in the rotate mode and in the explicit carry-rotate mode. A randomized sweep over all eight mode codes, with corner amounts mixed in, compares result and carry against a model written in the bench. This sweep also covers the unused codes.

// File: rtl/bsh_pkg.sv
// Shared definitions for the five-mode barrel shifter.
// Assumes mode codes are fixed by the instruction decoder that feeds the block.
package bsh_pkg;
    typedef enum logic [2:0] {
        MODE_SHL  = 3'd0,
        MODE_SHR  = 3'd1,
        MODE_SAR  = 3'd2,
        MODE_ROTR = 3'd3,
        MODE_RCX  = 3'd4
    } shift_mode_e;
endpackage

// File: rtl/bsh_rotator.sv
// Logarithmic right rotator: log2(WIDTH) stages, stage s rotates by 2**s.
// Assumes WIDTH is a power of two so that every amount maps onto a rotation.
module bsh_rotator #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] rot_amt,
    output logic [WIDTH-1:0] dout
);
    // Apply each binary-weighted rotation stage in turn.
    always_comb begin
        logic [WIDTH-1:0] acc;
        acc = din;
        for (int s = 0; s < AMT_W; s++) begin
            if (rot_amt[s]) begin
                acc = (acc >> (1 << s)) | (acc << (WIDTH - (1 << s)));
            end
        end
        dout = acc;
    end
endmodule

// File: rtl/bsh_fill_mask.sv
// Thermometer masks that mark the vacated bit positions for a given amount.
// low_mask has the amt lowest bits set; high_mask has the amt highest bits set.
module bsh_fill_mask #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] low_mask,
    output logic [WIDTH-1:0] high_mask
);
    // Build both masks one bit at a time from the amount.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            low_mask[i]  = (i < int'(amt));
            high_mask[i] = (i >= WIDTH - int'(amt));
        end
    end
endmodule

// File: rtl/bsh_bit_pick.sv
// Selects one operand bit by index; used to form the carry-out.
// Assumes idx is always below WIDTH (guaranteed when WIDTH is a power of two).
module bsh_bit_pick #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] idx,
    output logic             bit_o
);
    // Plain indexed select.
    assign bit_o = din[idx];
endmodule

// File: rtl/barrel_shift5.sv
// Five-mode barrel shifter for a data-processing operand.
// Every shift is built from one right rotator plus fill masks. A left shift by n
// is a right rotation by WIDTH-n. Purely combinational, so it has no clock or reset.
module barrel_shift5 #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] op_value,
    input  logic [2:0]       op_mode,
    input  logic [AMT_W-1:0] op_amount,
    input  logic             carry_in,
    output logic [WIDTH-1:0] shift_result,
    output logic             carry_out
);
    import bsh_pkg::*;

    localparam logic [AMT_W-1:0] AMT_ONE = AMT_W'(1);

    logic [AMT_W-1:0] neg_amt;
    logic [AMT_W-1:0] rot_amt;
    logic [AMT_W-1:0] pick_idx;
    logic [WIDTH-1:0] rotated;
    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] high_mask;
    logic             picked;
    logic             amt_zero;
    logic             use_rcx;

    assign neg_amt  = '0 - op_amount;
    assign amt_zero = (op_amount == '0);
    assign use_rcx  = (op_mode == MODE_RCX) || ((op_mode == MODE_ROTR) && amt_zero);

    // Choose the rotation distance and the carry bit index for the mode.
    always_comb begin
        if (op_mode == MODE_SHL) begin
            rot_amt  = neg_amt;
            pick_idx = neg_amt;
        end else begin
            rot_amt  = op_amount;
            pick_idx = op_amount - AMT_ONE;
        end
    end

    bsh_rotator #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_rot (
        .din     (op_value),
        .rot_amt (rot_amt),
        .dout    (rotated)
    );

    bsh_fill_mask #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_mask (
        .amt       (op_amount),
        .low_mask  (low_mask),
        .high_mask (high_mask)
    );

    bsh_bit_pick #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_pick (
        .din   (op_value),
        .idx   (pick_idx),
        .bit_o (picked)
    );

    // Combine the rotated word, the fill masks and the carry for the final outputs.
    always_comb begin
        shift_result = op_value;
        carry_out    = carry_in;
        if (use_rcx) begin
            shift_result = {carry_in, op_value[WIDTH-1:1]};
            carry_out    = op_value[0];
        end else if (!amt_zero) begin
            case (op_mode)
                MODE_SHL: begin
                    shift_result = rotated & ~low_mask;
                    carry_out    = picked;
                end
                MODE_SHR: begin
                    shift_result = rotated & ~high_mask;
                    carry_out    = picked;
                end
                MODE_SAR: begin
                    shift_result = (rotated & ~high_mask) | (high_mask & {WIDTH{op_value[WIDTH-1]}});
                    carry_out    = picked;
                end
                MODE_ROTR: begin
                    shift_result = rotated;
                    carry_out    = picked;
                end
                default: begin
                    shift_result = op_value;
                    carry_out    = carry_in;
                end
            endcase
        end
    end

    // Output-side checks against the mode semantics.
    always_comb begin
        if (op_mode == MODE_SHL && !amt_zero)
            assert_shl_low_zero_R1: assert (shift_result[0] == 1'b0);
        if (op_mode == MODE_SHR && !amt_zero)
            assert_shr_top_zero_R2: assert (shift_result[WIDTH-1] == 1'b0);
        if (op_mode == MODE_SAR)
            assert_sar_sign_kept_R3: assert (shift_result[WIDTH-1] == op_value[WIDTH-1]);
        if (op_mode == MODE_ROTR && !amt_zero)
            assert_rotr_popcount_R4: assert ($countones(shift_result) == $countones(op_value));
        if (op_mode <= MODE_SAR && amt_zero)
            assert_zero_amt_pass_R5: assert (shift_result == op_value && carry_out == carry_in);
        if (use_rcx)
            assert_rcx_carry_path_R7: assert (shift_result[WIDTH-1] == carry_in && carry_out == op_value[0]);
        if (op_mode > MODE_RCX)
            assert_unused_code_pass_R9: assert (shift_result == op_value && carry_out == carry_in);
    end
endmodule

// File: tb/test_barrel_shift5.sv
module test_barrel_shift5;
    logic        clk = 1'b0;
    logic [31:0] op_value;
    logic [2:0]  op_mode;
    logic [4:0]  op_amount;
    logic        carry_in;
    logic [31:0] shift_result;
    logic        carry_out;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;

    always #10 clk = ~clk;

    barrel_shift5 i_barrel_shift5 (
        .op_value     (op_value),
        .op_mode      (op_mode),
        .op_amount    (op_amount),
        .carry_in     (carry_in),
        .shift_result (shift_result),
        .carry_out    (carry_out)
    );

    // Entry layout: {mode[3], amount[5], cin, value[32], result[32], carry}
    localparam int NV = 18;
    localparam logic [73:0] VEC [NV] = '{
        {3'd0, 5'd8,  1'b0, 32'h92345678, 32'h34567800, 1'b0},
        {3'd1, 5'd8,  1'b1, 32'h92345678, 32'h00923456, 1'b0},
        {3'd2, 5'd8,  1'b0, 32'h92345678, 32'hFF923456, 1'b0},
        {3'd3, 5'd8,  1'b1, 32'h92345678, 32'h78923456, 1'b0},
        {3'd2, 5'd8,  1'b0, 32'h12345678, 32'h00123456, 1'b0},
        {3'd0, 5'd0,  1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1},
        {3'd1, 5'd0,  1'b0, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0},
        {3'd2, 5'd0,  1'b1, 32'h80000001, 32'h80000001, 1'b1},
        {3'd3, 5'd0,  1'b0, 32'h80000003, 32'h40000001, 1'b1},
        {3'd4, 5'd17, 1'b1, 32'h00000002, 32'h80000001, 1'b0},
        {3'd0, 5'd31, 1'b0, 32'h00000003, 32'h80000000, 1'b1},
        {3'd1, 5'd31, 1'b0, 32'hC0000000, 32'h00000001, 1'b1},
        {3'd2, 5'd31, 1'b0, 32'h80000000, 32'hFFFFFFFF, 1'b0},
        {3'd3, 5'd1,  1'b0, 32'h00000001, 32'h80000000, 1'b1},
        {3'd0, 5'd1,  1'b0, 32'h80000000, 32'h00000000, 1'b1},
        {3'd6, 5'd5,  1'b1, 32'h12345678, 32'h12345678, 1'b1},
        {3'd3, 5'd31, 1'b0, 32'h40000000, 32'h80000000, 1'b1},
        {3'd1, 5'd1,  1'b0, 32'h00000003, 32'h00000001, 1'b1}
    };

    // Independent model of the mode rules, returned as {carry, result}.
    function automatic logic [32:0] model(input logic [2:0] m, input logic [4:0] a,
                                          input logic c, input logic [31:0] v);
        int n = int'(a);
        logic [31:0] r = v;
        logic        co = c;
        if (m == 3'd4 || (m == 3'd3 && n == 0)) begin
            r = {c, v[31:1]};
            co = v[0];
        end else if (m <= 3'd3 && n != 0) begin
            for (int i = 0; i < 32; i++) begin
                case (m)
                    3'd0: r[i] = (i - n >= 0) ? v[i - n] : 1'b0;
                    3'd1: r[i] = (i + n < 32) ? v[i + n] : 1'b0;
                    3'd2: r[i] = (i + n < 32) ? v[i + n] : v[31];
                    default: r[i] = v[(i + n) % 32];
                endcase
            end
            co = (m == 3'd0) ? v[32 - n] : v[n - 1];
        end
        return {co, r};
    endfunction

    task automatic apply_check(input string req, input logic [2:0] m, input logic [4:0] a,
                               input logic c, input logic [31:0] v,
                               input logic [31:0] exp_r, input logic exp_c);
        @(negedge clk);
        op_mode = m; op_amount = a; carry_in = c; op_value = v;
        @(posedge clk);
        #5;
        n_checks++;
        if (shift_result !== exp_r || carry_out !== exp_c) begin
            n_fails++;
            $display("FAIL %s mode=%0d amt=%0d: actual=%h/%b expected=%h/%b",
                     req, m, a, shift_result, carry_out, exp_r, exp_c);
        end
    endtask

    function automatic string tag_for(input logic [2:0] m, input logic [4:0] a);
        if (m > 3'd4) return "R9";
        if (m == 3'd4) return "R8";
        if (a == 5'd0) return (m == 3'd3) ? "R7" : "R5";
        case (m)
            3'd0: return "R1/R6";
            3'd1: return "R2/R6";
            3'd2: return "R3/R6";
            default: return "R4/R6";
        endcase
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Table walk, then randomized sweep with corner amounts.
    initial begin
        logic [73:0] e;
        op_value = '0; op_mode = '0; op_amount = '0; carry_in = 1'b0;
        for (int k = 0; k < NV; k++) begin
            e = VEC[k];
            apply_check(tag_for(e[73:71], e[70:66]), e[73:71], e[70:66], e[65], e[64:33],
                        e[32:1], e[0]);
        end
        void'($urandom(7));
        for (int k = 0; k < 400; k++) begin
            logic [2:0]  m = 3'($urandom_range(7));
            logic [4:0]  a;
            logic        c = 1'($urandom);
            logic [31:0] v = $urandom;
            logic [32:0] ex;
            case (k % 4)
                0: a = 5'd0;
                1: a = 5'd1;
                2: a = 5'd31;
                default: a = 5'($urandom);
            endcase
            ex = model(m, a, c, v);
            apply_check(tag_for(m, a), m, a, c, v, ex[31:0], ex[32]);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: an unfinished run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule